// File: doc/BRIEF.md
# Sequence-Unlocked Watchdog Timer

This block is the watchdog of a small microcontroller. A prescaler divides the oscillator clock into machine cycles of twelve clocks. Once the watchdog is running, a fourteen-bit counter advances on each machine cycle. If software fails to service the counter before it wraps, the block drives a reset pulse of fixed length. Software cannot read or load the counter. Its only access is a write-only service register at one special-function address.

The watchdog is off after reset. Writing 0x1E and then 0xE1 to the service register starts it, and writing the same pair again restarts the count from zero. No write can stop it. Only a hardware reset or its own overflow pulse returns it to the off state. Three conditions suspend counting: idle mode, when the idle-hold bit is set; power-down; and, after power-down ends, the time for which the external wake interrupt pin is still held low. The CPU-side register bus is a plain single-cycle write strobe with no handshake, so the block never stalls a write.

Top module: `seq_wdt`

## Requirements
- R1: After `rst_n` is released, `wdt_rst` is low and the watchdog stays off. No pulse appears, however long the clock runs, until an enabling sequence is written.
- R2: A write of 0x1E followed by a write of 0xE1 to address 0xA6 enables the watchdog. If the watchdog is not serviced, `wdt_rst` rises after the clock edge that comes 16384 × 12 clocks after the edge that accepted the 0xE1 write. This is the edge on which the counter, already at 0x3FFF, takes one more machine-cycle step.
- R3: Writing the same pair while the watchdog runs clears both the prescaler and the counter. The overflow then moves to 16384 × 12 clocks after the second write.
- R4: Each overflow holds `wdt_rst` high for exactly 98 oscillator clocks. The overflow also returns the watchdog to the off state, so no later pulse follows without a new enabling sequence.
- R5: A running watchdog cannot be stopped. Writes of other values to address 0xA6 do not disable it, and they do not delay its overflow.
- R6: A 0xE1 write that does not come directly after a 0x1E write to address 0xA6 has no effect. Any other value written between the two bytes also cancels the pair. Writes to any other address are ignored.
- R7: When `idle_hold` = 0, counting continues in idle mode. When `idle_hold` = 1 and `idle` is high, counting pauses for those clocks and resumes when idle ends.
- R8: While `pdown` is high, counting stops. After power-down ends, counting stays paused while `wake_n` is low. It resumes on the first clock on which `wake_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Hardware reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Special-function address of the write |
| wr_data | input | 8 | Write data byte |
| idle | input | 1 | CPU is in idle mode |
| idle_hold | input | 1 | Control bit: 1 pauses counting during idle |
| pdown | input | 1 | CPU is in power-down |
| wake_n | input | 1 | External wake interrupt pin level, active low |
| wdt_rst | output | 1 | Watchdog reset pulse, active high |

## Verification
The assertions check three things on every cycle. Each pulse lasts exactly the fixed length. The output stays low right after reset. No pulse can begin on a clock in which power-down or held idle suspends counting. The bench scenarios cover everything that depends on the history of writes. These are the exact clock at which an overflow lands after enabling or servicing, the rejection of broken or misaddressed byte pairs, the delay added by held idle and by a low wake pin, and the fact that the block stays silent after an overflow.

// File: rtl/seq_wdt_pkg.sv
package seq_wdt_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;
endpackage

// File: rtl/seq_wdt_key.sv
// Tracks the two-byte service pair on the service register address.
module seq_wdt_key #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              flush,
  output logic              key_ok
);
  import seq_wdt_pkg::*;

  logic armed;
  logic hit;

  assign hit    = wr_en && (wr_addr == SVC_ADDR);
  assign key_ok = hit && armed && (wr_data == DATA_W'(KEY_SECOND));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (flush)  armed <= 1'b0;
    else if (hit)    armed <= (wr_data == DATA_W'(KEY_FIRST));
  end
endmodule

// File: rtl/seq_wdt_tick.sv
// Machine-cycle prescaler with idle, power-down and wake gating.
module seq_wdt_tick #(
  parameter int PRESC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic idle,
  input  logic idle_hold,
  input  logic pdown,
  input  logic wake_n,
  output logic tick
);
  localparam int PW = (PRESC > 2) ? $clog2(PRESC) : 1;
  localparam logic [PW-1:0] PMAX = PW'(PRESC - 1);

  logic [PW-1:0] presc;
  logic          pd_wait;
  logic          run;

  assign run  = en && !pdown && !(pd_wait && !wake_n) && !(idle && idle_hold);
  assign tick = run && (presc == PMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pd_wait <= 1'b0;
    else if (pdown)             pd_wait <= 1'b1;
    else if (wake_n)            pd_wait <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      presc <= '0;
    else if (clr)    presc <= '0;
    else if (run)    presc <= (presc == PMAX) ? '0 : presc + 1'b1;
  end
endmodule

// File: rtl/seq_wdt_count.sv
// Main counter: enable state, service clear and overflow detection.
module seq_wdt_count #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_ok,
  input  logic tick,
  output logic en,
  output logic fire
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt;

  assign fire = en && tick && (cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      cnt <= '0;
    end else if (fire) begin
      en  <= 1'b0;
      cnt <= '0;
    end else if (key_ok) begin
      en  <= 1'b1;
      cnt <= '0;
    end else if (tick && en) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/seq_wdt_pulse.sv
// Stretches an overflow event into a fixed-length reset pulse.
module seq_wdt_pulse #(
  parameter int RST_LEN = 98
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int LW = $clog2(RST_LEN + 1);

  logic [LW-1:0] left;

  assign pulse = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left <= '0;
    else if (fire)   left <= LW'(RST_LEN);
    else if (pulse)  left <= left - 1'b1;
  end
endmodule

// File: rtl/seq_wdt.sv
module seq_wdt #(
  parameter int CNT_W   = 14,
  parameter int PRESC   = 12,
  parameter int RST_LEN = 98,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 8'hA6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              idle,
  input  logic              idle_hold,
  input  logic              pdown,
  input  logic              wake_n,
  output logic              wdt_rst
);
  logic key_ok;
  logic tick;
  logic en;
  logic fire;

  seq_wdt_key #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR)) u_key (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && !wdt_rst), .wr_addr(wr_addr), .wr_data(wr_data),
    .flush(fire), .key_ok(key_ok)
  );

  seq_wdt_tick #(.PRESC(PRESC)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(key_ok || fire),
    .idle(idle), .idle_hold(idle_hold), .pdown(pdown), .wake_n(wake_n),
    .tick(tick)
  );

  seq_wdt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .key_ok(key_ok), .tick(tick),
    .en(en), .fire(fire)
  );

  seq_wdt_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(wdt_rst)
  );
endmodule

// File: rtl/seq_wdt_chk.sv
module seq_wdt_chk #(
  parameter int RST_LEN = 98
) (
  input logic clk,
  input logic rst_n,
  input logic idle,
  input logic idle_hold,
  input logic pdown,
  input logic wdt_rst
);
  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_len <= '0;
    else if (wdt_rst)  hi_len <= hi_len + 1'b1;
    else               hi_len <= '0;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !wdt_rst);

  a_r4_pulse_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst) |-> (hi_len == 16'(RST_LEN)));

  a_r7_idle_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && idle_hold && !wdt_rst) |=> !wdt_rst);

  a_r8_pdown_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown && !wdt_rst) |=> !wdt_rst);
endmodule

bind seq_wdt seq_wdt_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .idle_hold(idle_hold),
  .pdown(pdown), .wdt_rst(wdt_rst)
);

// File: tb/seq_wdt_bench.sv
module seq_wdt_bench;
  localparam int CW = 5;
  localparam int PS = 3;
  localparam int RL = 98;
  localparam int SPAN = (1 << CW) * PS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       idle = 1'b0;
  logic       idle_hold = 1'b0;
  logic       pdown = 1'b0;
  logic       wake_n = 1'b1;
  logic       wdt_rst;

  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int pulses = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seq_wdt #(.CNT_W(CW), .PRESC(PS), .RST_LEN(RL)) u_seq_wdt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .idle(idle), .idle_hold(idle_hold),
    .pdown(pdown), .wake_n(wake_n), .wdt_rst(wdt_rst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures each pulse and pops the expected rise edge.
  int rise_at = 0;
  int len = 0;
  logic prev = 1'b0;
  always @(negedge clk) begin
    if (wdt_rst && !prev) begin rise_at = cyc; len = 0; end
    if (wdt_rst) len++;
    if (!wdt_rst && prev) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1/R5 unexpected pulse", rise_at, -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rise_at == e, t, rise_at, e);
        check(len == RL, "R4 pulse length", len, RL);
      end
      pulses++;
    end
    prev = wdt_rst;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d, output int k);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    k = cyc;
    wr_en = 1'b0;
  endtask

  task automatic expect_pulse(input int at, input string t);
    exp_q.push_back(at);
    tag_q.push_back(t);
  endtask

  task automatic wait_pulse(input int n);
    wait (pulses == n);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int k, k2, d, base;
    repeat (4) @(negedge clk);
    check(wdt_rst == 1'b0, "R1 output low in reset", wdt_rst, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wdt_rst == 1'b0, "R1 output low after reset", wdt_rst, 0);

    // R1 and R6: nothing happens without a valid pair.
    wr(8'hA6, 8'hE1, d);
    wr(8'h50, 8'h1E, d);
    wr(8'h50, 8'hE1, d);
    wr(8'hA6, 8'h1E, d);
    wr(8'hA6, 8'h33, d);
    wr(8'hA6, 8'hE1, d);
    repeat (SPAN + 60) @(negedge clk);
    check(pulses == 0, "R1 R6 no pulse without valid pair", pulses, 0);

    // R2: plain enable then overflow.
    wr(8'hA6, 8'h1E, d);
    wr(8'hA6, 8'hE1, k);
    expect_pulse(k + SPAN, "R2 overflow timing");
    wait_pulse(1);

    // R4 and R5: disabled after overflow.
    repeat (SPAN + 40) @(negedge clk);
    check(pulses == 1, "R4 off after overflow", pulses, 1);

    // R3: servicing moves the overflow.
    wr(8'hA6, 8'h1E, d);
    wr(8'hA6, 8'hE1, k);
    repeat (50) @(negedge clk);
    wr(8'hA6, 8'h1E, d);
    wr(8'hA6, 8'hE1, k2);
    expect_pulse(k2 + SPAN, "R3 service restart");
    wait_pulse(2);

    // R5 and R6: broken pairs and other values do not service or disable.
    wr(8'hA6, 8'h1E, d);
    wr(8'hA6, 8'hE1, k);
    wr(8'hA6, 8'h1E, d);
    wr(8'hA6, 8'h55, d);
    wr(8'hA6, 8'hE1, d);
    wr(8'hA6, 8'h00, d);
    wr(8'h50, 8'h1E, d);
    wr(8'hA6, 8'hE1, d);
    expect_pulse(k + SPAN, "R5 R6 no disable or service");
    wait_pulse(3);

    // R7: idle without hold keeps counting.
    wr(8'hA6, 8'h1E, d);
    wr(8'hA6, 8'hE1, k);
    @(negedge clk); idle = 1'b1;
    repeat (20) @(negedge clk);
    idle = 1'b0;
    expect_pulse(k + SPAN, "R7 idle counts when hold=0");
    wait_pulse(4);

    // R7: idle with hold pauses.
    idle_hold = 1'b1;
    wr(8'hA6, 8'h1E, d);
    wr(8'hA6, 8'hE1, k);
    @(negedge clk); idle = 1'b1;
    repeat (25) @(negedge clk);
    idle = 1'b0;
    expect_pulse(k + SPAN + 25, "R7 idle pauses when hold=1");
    wait_pulse(5);
    idle_hold = 1'b0;

    // R8: power-down with wake pin high.
    wr(8'hA6, 8'h1E, d);
    wr(8'hA6, 8'hE1, k);
    @(negedge clk); pdown = 1'b1;
    repeat (20) @(negedge clk);
    pdown = 1'b0;
    expect_pulse(k + SPAN + 20, "R8 power-down stops count");
    wait_pulse(6);

    // R8: wake pin held low after power-down.
    wr(8'hA6, 8'h1E, d);
    wr(8'hA6, 8'hE1, k);
    @(negedge clk); pdown = 1'b1; wake_n = 1'b0;
    repeat (20) @(negedge clk);
    pdown = 1'b0;
    repeat (15) @(negedge clk);
    wake_n = 1'b1;
    expect_pulse(k + SPAN + 35, "R8 wait for wake pin high");
    wait_pulse(7);

    base = pulses;
    repeat (SPAN + 40) @(negedge clk);
    check(pulses == base, "R4 silent after last overflow", pulses, base);
    check(exp_q.size() == 0, "R2 all expected pulses seen", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc == 100000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule